// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an NRZ receive line into characters. A 16x sampling enable, taken from either an internal baud tick or an external 16x tick, paces a frame engine. The engine looks for a falling edge and confirms the start bit at its midpoint. It then samples each data bit, the optional parity bit and the first stop bit at their midpoints. A finished character is written to a receive data register. The parity bit is removed, and the bits above the programmed word length read as zero.

A status stage holds a receive-full flag and three error flags: overrun, framing and parity. The error flags always describe the most recently accepted character. A completed character that arrives while the register is still full is dropped, and the overrun flag is raised. The receiver runs only while the terminal-ready enable is on and the data-set-ready input is low. An echo selection loops the synchronized receive line back to the transmit line in place of the transmitter's own serial output.

Top module: `rxo_receiver`

## Requirements
- R1: Data bits are taken least significant bit first. The word length code `word_len` selects 5 + code data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Bits of `rx_data` above the word length read 0.
- R2: With `par_en`=1, one parity bit follows the data bits and is never stored. In mode `par_mode`=00 (odd) or 01 (even), a parity bit that does not give that parity sets `err_parity` for the character.
- R3: In mode `par_mode`=10 (mark) or 11 (space), the parity bit is consumed but not checked, and `err_parity` stays 0.
- R4: A start bit is confirmed by a sample at its 8th tick. If the line is high at that point, the receiver returns to idle and stores nothing.
- R5: `rx_full` goes to 1 in the cycle after the stop-bit sample of an accepted character. A one-cycle `rd_strobe` pulse clears it.
- R6: A first stop bit sampled low sets `err_framing` for that character.
- R7: A character that completes while `rx_full`=1 sets `err_overrun`. It leaves `rx_data`, `err_parity` and `err_framing` unchanged.
- R8: The error flags change only when a character completes, and a read leaves them as they are. After a read, a character with no error clears all three flags.
- R9: The receiver operates only while `dtr_on`=1 and `dsr_n`=0. At any other time, line activity stores nothing.
- R10: When `echo_on`=1 and `tx_ctrl`=00, `tx_line` follows the receive line after 2 clock cycles. Otherwise `tx_line` equals `tx_serial_in`.
- R11: `clk_sel`=0 paces sampling with `tick_int`, and `clk_sel`=1 paces it with `tick_ext`.
- R12: After reset, `rx_data` is 0 and `rx_full`, `err_overrun`, `err_framing` and `err_parity` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_int | input | 1 | Internal 16x sampling enable |
| tick_ext | input | 1 | External 16x sampling enable |
| clk_sel | input | 1 | 0: internal tick, 1: external tick |
| dtr_on | input | 1 | Terminal-ready enable |
| dsr_n | input | 1 | Data-set-ready, active low |
| rx_line | input | 1 | Asynchronous serial input |
| word_len | input | 2 | Word length code (5 + code bits) |
| par_en | input | 1 | Parity bit present |
| par_mode | input | 2 | 00 odd, 01 even, 10 mark, 11 space |
| echo_on | input | 1 | Echo selection |
| tx_ctrl | input | 2 | Transmit control code; echo needs 00 |
| tx_serial_in | input | 1 | Transmitter serial output |
| rd_strobe | input | 1 | Data register read pulse |
| rx_data | output | 8 | Received character |
| rx_full | output | 1 | Receive register full |
| err_overrun | output | 1 | Overrun flag |
| err_framing | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| tx_line | output | 1 | Transmit line |

## Verification
The checker covers, on every cycle, the rules that tie the status stage to its inputs. A read of a full register empties it, and held data stays put until a read. An overrun follows a completion into a full register. Data and error flags change only on a completion, and nothing is stored while the receiver is disabled. Only the bench's serial scenarios can show the rest: correct bit order and zero fill for each word length, the parity decisions per mode, false-start rejection, framing detection, tick source selection and the echo path. Each of these needs a whole frame driven on the line and a comparison against values computed from the requirements.

// File: rtl/rxo_pkg.sv
// Shared types for the oversampling receiver.
package rxo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
    } rx_state_t;

    typedef enum logic [1:0] {
        PM_ODD = 2'b00, PM_EVEN = 2'b01, PM_MARK = 2'b10, PM_SPACE = 2'b11
    } par_mode_t;
endpackage

// File: rtl/rxo_sync.sv
// Multi-stage synchronizer for an asynchronous single-bit input.
// Assumes STAGES >= 2; resets every stage to RST_VAL (line idle level).
module rxo_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the input one stage further per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pipe[i] <= RST_VAL;
                else if (i == 0)
                    pipe[i] <= d;
                else
                    pipe[i] <= pipe[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rxo_frame.sv
// Frame engine: finds a start bit, confirms it at mid-bit, samples data,
// parity and first stop bit at their midpoints on the OSR-times tick.
// Assumes rxd is already synchronized and configuration is stable per frame.
module rxo_frame
    import rxo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] char_out,
    output logic              fe,
    output logic              pe
);
    localparam int CNT_W    = $clog2(OSR);
    localparam int BIDX_W   = $clog2(DATA_W + 1);
    localparam int MIN_BITS = DATA_W - 3;
    localparam logic [CNT_W-1:0] MID = CNT_W'(OSR/2 - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   cnt;
    logic [BIDX_W-1:0]  bidx;
    logic [DATA_W-1:0]  shreg;
    logic               pbit;
    logic [BIDX_W-1:0]  nbits;
    logic [BIDX_W-1:0]  sh_amt;
    logic               mid;
    logic               ones;

    assign nbits  = BIDX_W'(MIN_BITS) + BIDX_W'(word_len);
    assign sh_amt = BIDX_W'(DATA_W) - nbits;
    assign mid    = tick && (cnt == MID);

    // Bit sequencer: tick counter, bit index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
        end else if (tick) begin
            cnt <= (state == ST_IDLE) ? '0 : cnt + 1'b1;
            unique case (state)
                ST_IDLE:  if (!rxd) state <= ST_START;
                ST_START: if (mid) begin
                              state <= rxd ? ST_IDLE : ST_DATA;
                              bidx  <= '0;
                          end
                ST_DATA:  if (mid) begin
                              shreg <= {rxd, shreg[DATA_W-1:1]};
                              bidx  <= bidx + 1'b1;
                              if (bidx == nbits - 1'b1)
                                  state <= par_en ? ST_PAR : ST_STOP;
                          end
                ST_PAR:   if (mid) begin
                              pbit  <= rxd;
                              state <= ST_STOP;
                          end
                ST_STOP:  if (mid) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Completion pulse and character results at the stop-bit midpoint.
    always_comb begin
        done     = active && mid && (state == ST_STOP);
        char_out = shreg >> sh_amt;
        fe       = !rxd;
        ones     = ^char_out;
        unique case (par_mode_t'(par_mode))
            PM_ODD:  pe = par_en && !(ones ^ pbit);
            PM_EVEN: pe = par_en &&  (ones ^ pbit);
            default: pe = 1'b0;
        endcase
    end
endmodule

// File: rtl/rxo_status.sv
// Receive data register with full, overrun, framing and parity flags.
// A completion into an empty register loads data and flags; into a full
// register it only raises overrun. Reads clear the full flag only.
module rxo_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] char_in,
    input  logic              fe_in,
    input  logic              pe_in,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] data,
    output logic              full,
    output logic              ovr,
    output logic              fe,
    output logic              pe
);
    // Register update on completion and on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            full <= 1'b0;
            ovr  <= 1'b0;
            fe   <= 1'b0;
            pe   <= 1'b0;
        end else begin
            if (done && !full) begin
                data <= char_in;
                full <= 1'b1;
                fe   <= fe_in;
                pe   <= pe_in;
                ovr  <= 1'b0;
            end else if (rd_strobe) begin
                full <= 1'b0;
            end
            if (done && full)
                ovr <= 1'b1;
        end
    end
endmodule

// File: rtl/rxo_receiver.sv
// Top: tick source select, line synchronizer, frame engine, status
// register and echo path. Assumes tick inputs are one-cycle enables.
module rxo_receiver #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_int,
    input  logic              tick_ext,
    input  logic              clk_sel,
    input  logic              dtr_on,
    input  logic              dsr_n,
    input  logic              rx_line,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic [1:0]        par_mode,
    input  logic              echo_on,
    input  logic [1:0]        tx_ctrl,
    input  logic              tx_serial_in,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              err_overrun,
    output logic              err_framing,
    output logic              err_parity,
    output logic              tx_line
);
    logic              rxd;
    logic              tick;
    logic              rx_active;
    logic              frame_done;
    logic [DATA_W-1:0] frame_char;
    logic              frame_fe;
    logic              frame_pe;

    // Source select, enable qualification and echo routing.
    always_comb begin
        tick      = clk_sel ? tick_ext : tick_int;
        rx_active = dtr_on && !dsr_n;
        tx_line   = (echo_on && (tx_ctrl == 2'b00)) ? rxd : tx_serial_in;
    end

    rxo_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rxd)
    );

    rxo_frame #(.DATA_W(DATA_W), .OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .active(rx_active), .tick(tick),
        .rxd(rxd), .word_len(word_len), .par_en(par_en),
        .par_mode(par_mode), .done(frame_done), .char_out(frame_char),
        .fe(frame_fe), .pe(frame_pe)
    );

    rxo_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .done(frame_done), .char_in(frame_char),
        .fe_in(frame_fe), .pe_in(frame_pe), .rd_strobe(rd_strobe),
        .data(rx_data), .full(rx_full), .ovr(err_overrun),
        .fe(err_framing), .pe(err_parity)
    );
endmodule

// File: rtl/rxo_checker.sv
// Cycle-level rules between the frame engine, status register and ports.
module rxo_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_strobe,
    input logic              rx_full,
    input logic [DATA_W-1:0] rx_data,
    input logic              err_overrun,
    input logic              err_framing,
    input logic              err_parity,
    input logic              frame_done,
    input logic              rx_active
);
    // R5: a read of a full register empties it.
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe && rx_full |=> !rx_full);

    // R7: held data is not overwritten until read.
    a_r7_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && !rd_strobe |=> $stable(rx_data));

    // R7: completion into a full register raises overrun.
    a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full && frame_done |=> err_overrun);

    // R8: data and error flags move only on a completion.
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable({rx_data, err_framing, err_parity}));

    // R9: nothing is stored while disabled.
    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_active |=> !$rose(rx_full));
endmodule

bind rxo_receiver rxo_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rx_full(rx_full),
    .rx_data(rx_data), .err_overrun(err_overrun), .err_framing(err_framing),
    .err_parity(err_parity), .frame_done(frame_done), .rx_active(rx_active)
);

// File: tb/tb_rxo_receiver.sv
module tb_rxo_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_int = 1'b0, tick_ext = 1'b0, clk_sel = 1'b0;
    logic       dtr_on = 1'b1, dsr_n = 1'b0, rx_line = 1'b1;
    logic [1:0] word_len = 2'b11, par_mode = 2'b00, tx_ctrl = 2'b10;
    logic       par_en = 1'b0, echo_on = 1'b0, tx_serial_in = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_full, err_overrun, err_framing, err_parity, tx_line;

    int n_checks = 0, n_fail = 0;
    int tcnt = 0;

    typedef struct {
        logic [7:0] d;
        bit full, ovr, fe, pe;
        string req;
    } exp_t;
    exp_t q[$];

    logic [7:0] m_data = 8'h00;
    bit m_full = 0, m_ovr = 0, m_fe = 0, m_pe = 0;

    always #5 clk = ~clk;

    rxo_receiver dut (
        .clk(clk), .rst_n(rst_n), .tick_int(tick_int), .tick_ext(tick_ext),
        .clk_sel(clk_sel), .dtr_on(dtr_on), .dsr_n(dsr_n), .rx_line(rx_line),
        .word_len(word_len), .par_en(par_en), .par_mode(par_mode),
        .echo_on(echo_on), .tx_ctrl(tx_ctrl), .tx_serial_in(tx_serial_in),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_full(rx_full),
        .err_overrun(err_overrun), .err_framing(err_framing),
        .err_parity(err_parity), .tx_line(tx_line)
    );

    // Tick generators: internal every 4 clocks, external every 2 (R11).
    always @(negedge clk) begin
        tcnt++;
        tick_int = (tcnt % 4 == 0);
        tick_ext = (tcnt % 2 == 1);
    end

    task automatic check(input string req, input string what, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic push(input string req);
        exp_t e;
        e.d = m_data; e.full = m_full; e.ovr = m_ovr; e.fe = m_fe; e.pe = m_pe; e.req = req;
        q.push_back(e);
        repeat (3) @(negedge clk);
    endtask

    // Monitor: pop expected items and compare with the outputs.
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            @(negedge clk);
            e = q.pop_front();
            check(e.req, "rx_data", int'(rx_data), int'(e.d));
            check(e.req, "rx_full", int'(rx_full), int'(e.full));
            check(e.req, "err_overrun", int'(err_overrun), int'(e.ovr));
            check(e.req, "err_framing", int'(err_framing), int'(e.fe));
            check(e.req, "err_parity", int'(err_parity), int'(e.pe));
        end
    end

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: send one frame, update the model from the requirements.
    task automatic send(input string req, input logic [7:0] d, input int nb,
                        input bit bad_par, input bit bad_stop, input bit takes);
        int bc = clk_sel ? 32 : 64;
        logic [7:0] m = d & 8'((1 << nb) - 1);
        logic p;
        word_len = 2'(nb - 5);
        @(negedge clk);
        rx_line = 1'b0; hold(bc);
        for (int i = 0; i < nb; i++) begin
            rx_line = m[i]; hold(bc);
        end
        if (par_en) begin
            case (par_mode)
                2'b00: p = ~^m;
                2'b01: p = ^m;
                2'b10: p = 1'b1;
                default: p = 1'b0;
            endcase
            rx_line = p ^ bad_par; hold(bc);
        end
        if (bad_stop) begin
            rx_line = 1'b0; hold(bc * 10 / 16);
            rx_line = 1'b1; hold(bc * 2);
        end else begin
            rx_line = 1'b1; hold(bc * 2);
        end
        if (takes) begin
            if (m_full) m_ovr = 1;
            else begin
                m_data = m; m_full = 1; m_ovr = 0; m_fe = bad_stop;
                m_pe = par_en && (par_mode < 2) && bad_par;
            end
        end
        push(req);
    endtask

    task automatic do_read(input string req);
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
        m_full = 0;
        push(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        hold(5);
        rst_n = 1'b1;
        push("R12 reset");
        // R1 word lengths, LSB first, zero fill
        send("R1 8bit", 8'hA5, 8, 0, 0, 1);  do_read("R5 read");
        send("R1 5bit", 8'hF3, 5, 0, 0, 1);  do_read("R5 read");
        send("R1 6bit", 8'hEE, 6, 0, 0, 1);  do_read("R5 read");
        // R2 parity checked and stripped
        par_en = 1; par_mode = 2'b01;
        send("R2 even ok", 8'h5A, 7, 0, 0, 1); do_read("R5 read");
        par_mode = 2'b00;
        send("R2 odd ok", 8'h2C, 6, 0, 0, 1);  do_read("R5 read");
        send("R2 odd bad", 8'hC3, 8, 1, 0, 1);
        // R7 overrun keeps data and flags
        send("R7 overrun", 8'h11, 8, 0, 0, 1);
        do_read("R8 read keeps flags");
        send("R8 clean clears", 8'h3C, 8, 0, 0, 1); do_read("R5 read");
        // R3 mark and space unchecked
        par_mode = 2'b10;
        send("R3 mark", 8'h81, 8, 1, 0, 1);  do_read("R5 read");
        par_mode = 2'b11;
        send("R3 space", 8'h7E, 8, 1, 0, 1); do_read("R5 read");
        par_en = 0;
        // R6 framing
        send("R6 framing", 8'h96, 8, 0, 1, 1); do_read("R5 read");
        send("R8 clean after framing", 8'h69, 8, 0, 0, 1); do_read("R5 read");
        // R4 false start
        @(negedge clk); rx_line = 1'b0; hold(20); rx_line = 1'b1; hold(200);
        push("R4 false start");
        send("R4 after glitch", 8'h4D, 8, 0, 0, 1); do_read("R5 read");
        // R9 disabled
        dsr_n = 1;
        send("R9 dsr off", 8'hFF, 8, 0, 0, 0);
        dsr_n = 0; dtr_on = 0;
        send("R9 dtr off", 8'h0F, 8, 0, 0, 0);
        dtr_on = 1;
        // R11 external tick
        clk_sel = 1;
        send("R11 ext tick", 8'hB7, 8, 0, 0, 1); do_read("R5 read");
        clk_sel = 0;
        // R10 echo path and passthrough
        @(negedge clk); tx_serial_in = 1'b1; echo_on = 1; tx_ctrl = 2'b00;
        rx_line = 1'b0; hold(3);
        check("R10", "echo low", int'(tx_line), 0);
        rx_line = 1'b1; hold(3);
        check("R10", "echo high", int'(tx_line), 1);
        tx_ctrl = 2'b01; tx_serial_in = 1'b0; hold(1);
        check("R10", "no echo when tx_ctrl busy", int'(tx_line), 0);
        echo_on = 0; tx_ctrl = 2'b00; tx_serial_in = 1'b1; rx_line = 1'b0; hold(3);
        check("R10", "passthrough", int'(tx_line), 1);
        rx_line = 1'b1; hold(200);
        wait (q.size() == 0);
        hold(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule